// File: doc/BRIEF.md
# Gated Multichannel Timestamp Event Recorder

This block watches eight asynchronous event inputs and one gate input. While the gate is open, every rising edge on an event input is timestamped. The timestamp counts ticks from the moment the gate opened. A tick is produced by a programmable divider of the system clock. Captures are packed into 32-bit markers and pushed out on a one-cycle write strobe with a 32-bit data word, which is meant to feed an external FIFO.

Each gate produces one packet of markers. A packet holds an optional start marker, any number of hit markers, overflow markers when the timestamp wraps, and an optional end marker. The gate can close in two ways. If the programmed gate time is zero, the gate input's falling edge closes it. Otherwise it closes after the programmed number of ticks, and a retrigger option can restart the acquisition. A small write-only configuration file sets up the block. A clear-on-read register returns the most recent marker.

Configuration map (`cfg_addr`):
- Address 0 is the control register. Its fields are described in R7, R8 and R10.
- Address 1 is the 32-bit divider. Its reset value is 1.
- Address 2 is the 32-bit gate time. Its reset value is 0.

Top module: `gated_stamp_rec`

## Requirements
- R1: Every marker carries the channel hit mask in bits 31..24, where bit 24+n stands for channel n. The timestamp sits in the low bits, zero-extended from the counter width `TS_W` (default 24).
- R2: Rising edges on several channels that are reported in the same tick produce one marker with all of their mask bits set. For example, channels 0 and 1 together give mask 0x03.
- R3: When the gate opens, a start marker of value 0x00000000 is written and the timestamp restarts at zero.
  - The timestamp advances by one on each tick.
  - A hit is reported at the next tick, with the new count.
  - An edge seen in the same cycle as the gate opening is reported with time 1 when the divider is 1.
- R4: A tick that wraps the timestamp counter writes an overflow marker. Its mask is 0x00 and its time field is all ones of `TS_W` (0xFFFFFF at the default width). Later hits carry the wrapped count.
- R5: With gate time zero, the synchronised falling edge of the gate input closes the gate. It writes an end marker with mask 0x00 and the current count. The count is forced to 1 if it is zero, so the end time is never zero.
- R6: With a non-zero gate time G, the gate closes at the tick whose count since opening reaches G, and the end marker carries that count. Falling edges of the gate input are ignored in this mode.
- R7: Control bit 0 suppresses end markers and control bit 1 suppresses start markers. Both work the same way in either gate mode.
- R8: With control bit 2 set and a non-zero gate time, a gate rising edge while the gate is open restarts the acquisition. The timestamp returns to zero, a new start marker is written and a fresh gate time begins. With bit 2 clear, such an edge is ignored.
- R9: A tick occurs once every N system clocks while the gate is open, where N is the divider value. A divider of 0 or 1 gives one tick per clock.
- R10: Control bits 6..4 delay the event inputs relative to the gate by 0 to 7 system clocks.
- R11: The event register returns the last marker written on the bus and reads as zero after reset. A read pulse clears it, unless a marker is written in the same cycle.
- R12: Markers go out as single-cycle strobes.
  - When several markers are due in one tick, they go out on consecutive cycles in the order overflow, hit, end.
  - A start marker always precedes the hits of its gate.
- R13: Event edges while the gate is closed are ignored. Edges still waiting for a tick when the gate closes are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_in | input | 1 | Asynchronous gate input |
| chan_in | input | 8 | Asynchronous event inputs |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| evt_rd | input | 1 | Clear-on-read pulse for the event register |
| evt_rdata | output | 32 | Most recent marker |
| bus_wr | output | 1 | Marker write strobe |
| bus_data | output | 32 | Marker data |

## Verification
The hardest situation to reach from the ports is the one where a counter wrap, a hit and the gate close all land in the same tick. Only then does the fixed overflow, hit, end ordering matter, and only then is an end time forced away from zero.

The bench builds the block with an 8-bit timestamp so that the wrap comes after 256 ticks. It then places one channel edge and the gate's falling edge exactly at tick 256. This relies on both inputs passing through identical synchroniser stages, which keeps them cycle-aligned with each other. The bench checks that the three markers arrive on consecutive cycles.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
    localparam int MARK_W = 32;
    localparam int MASK_W = 8;
    localparam int TIME_W = 24;
    localparam int DLY_W  = 3;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_DIV   = 2'd1;
    localparam logic [1:0] ADDR_GTIME = 2'd2;

    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic             retrig;
        logic             no_start;
        logic             no_end;
    } ctrl_t;

    function automatic logic [MARK_W-1:0] pack_marker(input logic [MASK_W-1:0] m,
                                                      input logic [TIME_W-1:0] t);
        return {m, t};
    endfunction
endpackage

// File: rtl/gsr_in_cond.sv
// Two-flop synchroniser, selectable delay line and edge detector.
module gsr_in_cond #(
    parameter int W     = 8,
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     raw,
    input  logic [DLY_W-1:0] dly,
    output logic [W-1:0]     rise,
    output logic [W-1:0]     fall
);
    localparam int DEPTH = (1 << DLY_W) - 1;

    logic [W-1:0] s1_q, s2_q, prev_q, tap;
    logic [W-1:0] line_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q      <= '0;
            s2_q      <= '0;
            prev_q    <= '0;
            line_q[0] <= '0;
        end else begin
            s1_q      <= raw;
            s2_q      <= s1_q;
            prev_q    <= tap;
            line_q[0] <= s2_q;
        end
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) line_q[i] <= '0;
            else        line_q[i] <= line_q[i-1];
        end
    end

    always_comb begin
        if (dly == '0) tap = s2_q;
        else           tap = line_q[dly - 1'b1];
    end

    assign rise = tap & ~prev_q;
    assign fall = ~tap & prev_q;
endmodule

// File: rtl/gsr_tick_div.sv
// Tick enable: one pulse every N clocks while running, N = max(div, 1).
module gsr_tick_div (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        restart,
    input  logic [31:0] div,
    output logic        tick
);
    logic [31:0] cnt_q, limit;

    assign limit = (div == 32'd0) ? 32'd1 : div;
    assign tick  = run && !restart && (cnt_q == limit - 32'd1);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) cnt_q <= '0;
        else if (tick)                 cnt_q <= '0;
        else                           cnt_q <= cnt_q + 32'd1;
    end
endmodule

// File: rtl/gsr_cfg.sv
// Write-only configuration registers.
module gsr_cfg
    import gsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output ctrl_t       ctrl,
    output logic [31:0] div,
    output logic [31:0] gtime
);
    logic unused_bits;
    assign unused_bits = ^{wdata[31:7], wdata[3]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            div   <= 32'd1;
            gtime <= 32'd0;
        end else if (we) begin
            case (addr)
                ADDR_CTRL: begin
                    ctrl.no_end   <= wdata[0];
                    ctrl.no_start <= wdata[1];
                    ctrl.retrig   <= wdata[2];
                    ctrl.dly      <= wdata[6:4];
                end
                ADDR_DIV:   div   <= wdata;
                ADDR_GTIME: gtime <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gated_stamp_rec.sv
module gated_stamp_rec
    import gsr_pkg::*;
#(
    parameter int TS_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_in,
    input  logic [MASK_W-1:0] chan_in,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              evt_rd,
    output logic [MARK_W-1:0] evt_rdata,
    output logic              bus_wr,
    output logic [MARK_W-1:0] bus_data
);
    typedef struct packed {
        logic              open;
        logic [TS_W-1:0]   ts;
        logic [31:0]       run;
        logic [MASK_W-1:0] pend;
        logic              st_v;
        logic              ov_v;
        logic              hit_v;
        logic [MARK_W-1:0] hit_m;
        logic              end_v;
        logic [MARK_W-1:0] end_m;
        logic              wr;
        logic [MARK_W-1:0] data;
        logic [MARK_W-1:0] last;
    } core_t;

    core_t q, d;
    ctrl_t ctrl;
    logic [31:0] div, gtime;
    logic [MASK_W-1:0] ch_rise, unused_ch_fall;
    logic g_rise, g_fall, tick, gate_open, restart;
    logic [TS_W-1:0] ts_cur;

    assign gate_open = q.open;
    assign ts_cur    = q.ts;

    gsr_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ctrl(ctrl), .div(div), .gtime(gtime)
    );

    gsr_in_cond #(.W(MASK_W), .DLY_W(DLY_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .raw(chan_in), .dly(ctrl.dly),
        .rise(ch_rise), .fall(unused_ch_fall)
    );

    gsr_in_cond #(.W(1), .DLY_W(1)) u_gate (
        .clk(clk), .rst_n(rst_n), .raw(gate_in), .dly(1'b0),
        .rise(g_rise), .fall(g_fall)
    );

    gsr_tick_div u_div (
        .clk(clk), .rst_n(rst_n), .run(gate_open), .restart(restart),
        .div(div), .tick(tick)
    );

    assign restart = gate_open && g_rise && ctrl.retrig && (gtime != 32'd0);

    always_comb begin
        logic [MASK_W-1:0] newpend;
        logic [TS_W-1:0]   ts_nx;
        logic [31:0]       run_nx;
        logic              close;

        d       = q;
        d.wr    = 1'b0;
        newpend = q.pend | ch_rise;
        ts_nx   = ts_cur;
        run_nx  = q.run;
        close   = 1'b0;

        // marker drain, fixed priority: start, overflow, hit, end
        if (q.st_v) begin
            d.wr = 1'b1; d.data = '0; d.st_v = 1'b0;
        end else if (q.ov_v) begin
            d.wr = 1'b1; d.data = pack_marker('0, TIME_W'({TS_W{1'b1}})); d.ov_v = 1'b0;
        end else if (q.hit_v) begin
            d.wr = 1'b1; d.data = q.hit_m; d.hit_v = 1'b0;
        end else if (q.end_v) begin
            d.wr = 1'b1; d.data = q.end_m; d.end_v = 1'b0;
        end

        if ((!q.open && g_rise) || restart) begin
            d.open = 1'b1;
            d.ts   = '0;
            d.run  = '0;
            d.pend = ch_rise;
            if (!ctrl.no_start) d.st_v = 1'b1;
        end else if (q.open) begin
            if (tick) begin
                run_nx = q.run + 32'd1;
                ts_nx  = ts_cur + 1'b1;
                if (ts_cur == '1) d.ov_v = 1'b1;
                if (newpend != '0) begin
                    d.hit_v = 1'b1;
                    d.hit_m = pack_marker(newpend, TIME_W'(ts_nx));
                end
                newpend = '0;
                if (gtime != 32'd0 && run_nx == gtime) close = 1'b1;
            end
            if (gtime == 32'd0 && g_fall) close = 1'b1;
            d.ts  = ts_nx;
            d.run = run_nx;
            if (close) begin
                d.open = 1'b0;
                d.pend = '0;
                if (!ctrl.no_end) begin
                    d.end_v = 1'b1;
                    d.end_m = pack_marker('0, (ts_nx == '0) ? TIME_W'(1) : TIME_W'(ts_nx));
                end
            end else begin
                d.pend = newpend;
            end
        end

        if (d.wr)        d.last = d.data;
        else if (evt_rd) d.last = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_wr    = q.wr;
    assign bus_data  = q.data;
    assign evt_rdata = q.last;
endmodule

// File: rtl/gsr_checker.sv
module gsr_checker #(
    parameter int TS_W = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            gate_open,
    input logic [TS_W-1:0] ts_cur,
    input logic            bus_wr,
    input logic [31:0]     bus_data,
    input logic            evt_rd,
    input logic [31:0]     evt_rdata
);
    assert_open_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_open) |-> ts_cur == '0);

    assert_ts_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open && $past(gate_open) |->
            (ts_cur == $past(ts_cur)) || (ts_cur == $past(ts_cur) + 1'b1) || (ts_cur == '0));

    assert_last_tracks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> evt_rdata == bus_data);

    assert_read_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rd |=> (bus_wr || evt_rdata == 32'd0));
endmodule

bind gated_stamp_rec gsr_checker #(.TS_W(TS_W)) u_gsr_checker (
    .clk(clk), .rst_n(rst_n), .gate_open(gate_open), .ts_cur(ts_cur),
    .bus_wr(bus_wr), .bus_data(bus_data), .evt_rd(evt_rd), .evt_rdata(evt_rdata)
);

// File: tb/test_gated_stamp_rec.sv
`timescale 1ns/1ps
module test_gated_stamp_rec;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0, gate_in = 0, cfg_we = 0, evt_rd = 0;
    logic [7:0] chan_in = '0;
    logic [1:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] evt_rdata, bus_data;
    logic bus_wr;

    int checks = 0, failures = 0, cyc = 0, nmk = 0;
    bit done = 0;
    logic [31:0] mk [32];
    int mc [32];
    logic [31:0] ex [8];

    gated_stamp_rec #(.TS_W(8)) i_gated_stamp_rec (
        .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .chan_in(chan_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .evt_rd(evt_rd), .evt_rdata(evt_rdata), .bus_wr(bus_wr), .bus_data(bus_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (bus_wr && nmk < 32) begin
        mk[nmk] = bus_data; mc[nmk] = cyc; nmk = nmk + 1;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_list(input string req, input int n);
        chk({req, " count"}, nmk, n);
        for (int i = 0; i < n && i < nmk; i++) chk(req, mk[i], ex[i]);
    endtask

    task automatic cfg(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic t_reset;
        chk("R11 reset evt", evt_rdata, 32'd0);
        chk("R12 reset strobe", {31'd0, bus_wr}, 32'd0);
    endtask

    // R1 R2 R3 R5: basic packet in gate-input mode
    task automatic t_basic;
        nmk = 0;
        @(negedge clk); gate_in = 1;
        step(4); chan_in = 8'h01;
        step(1); chan_in = 8'h00;
        step(4); chan_in = 8'h03;
        step(1); chan_in = 8'h00;
        step(5); gate_in = 0;
        step(12);
        ex[0] = 32'h0; ex[1] = 32'h01000004; ex[2] = 32'h03000009; ex[3] = 32'h0000000F;
        check_list("R1 R2 R3 R5 basic", 4);
    endtask

    // R10 delay, R3 edge coinciding with gate opening
    task automatic t_delay;
        cfg(2'd0, 32'h30);
        nmk = 0;
        @(negedge clk); gate_in = 1; chan_in = 8'h10;
        step(1); chan_in = 8'h00;
        step(19); gate_in = 0;
        step(12);
        ex[0] = 32'h0; ex[1] = 32'h10000003; ex[2] = 32'h00000014;
        check_list("R10 delay 3", 3);
        cfg(2'd0, 32'h0);
        nmk = 0;
        @(negedge clk); gate_in = 1; chan_in = 8'h04;
        step(1); chan_in = 8'h00;
        step(2); gate_in = 0;
        step(12);
        ex[0] = 32'h0; ex[1] = 32'h04000001; ex[2] = 32'h00000003;
        check_list("R3 same-cycle edge", 3);
    endtask

    // R9 divider, R2 merge across a tick period, R13 discard at close
    task automatic t_divider;
        cfg(2'd1, 32'd4);
        nmk = 0;
        @(negedge clk); gate_in = 1;
        step(5); chan_in = 8'h01;
        step(1); chan_in = 8'h00;
        step(2); chan_in = 8'h08;
        step(1); chan_in = 8'h80;
        step(1); chan_in = 8'h00;
        step(3); chan_in = 8'h20;
        step(1); chan_in = 8'h00; gate_in = 0;
        step(20);
        ex[0] = 32'h0; ex[1] = 32'h09000002; ex[2] = 32'h80000003; ex[3] = 32'h00000003;
        check_list("R9 R2 R13 divider", 4);
        cfg(2'd1, 32'd1);
    endtask

    // R6 gate time, R8 retrigger
    task automatic gt_stim;
        @(negedge clk); gate_in = 1;
        step(2); gate_in = 0;
        step(1); chan_in = 8'h02;
        step(1); chan_in = 8'h00;
        step(1); gate_in = 1;
        step(2); gate_in = 0;
        step(20);
    endtask

    task automatic t_gate_time;
        cfg(2'd2, 32'd10);
        nmk = 0; gt_stim;
        ex[0] = 32'h0; ex[1] = 32'h02000003; ex[2] = 32'h0000000A;
        check_list("R6 R8 no retrigger", 3);
        cfg(2'd0, 32'h4);
        nmk = 0; gt_stim;
        ex[0] = 32'h0; ex[1] = 32'h02000003; ex[2] = 32'h0; ex[3] = 32'h0000000A;
        check_list("R8 retrigger", 4);
        cfg(2'd0, 32'h0);
        cfg(2'd2, 32'd0);
    endtask

    // R7 suppression, R13 edges outside the gate
    task automatic t_suppress;
        cfg(2'd0, 32'h3);
        nmk = 0;
        @(negedge clk); chan_in = 8'hFF;
        step(1); chan_in = 8'h00;
        step(5); gate_in = 1;
        step(6); chan_in = 8'h04;
        step(1); chan_in = 8'h00;
        step(2); gate_in = 0;
        step(5); chan_in = 8'hFF;
        step(1); chan_in = 8'h00;
        step(12);
        ex[0] = 32'h04000006;
        check_list("R7 R13 suppress", 1);
        cfg(2'd0, 32'h0);
    endtask

    // R4 overflow then wrapped hit
    task automatic t_wrap;
        nmk = 0;
        @(negedge clk); gate_in = 1;
        step(258); chan_in = 8'h10;
        step(1); chan_in = 8'h00;
        step(2); gate_in = 0;
        step(12);
        ex[0] = 32'h0; ex[1] = 32'h000000FF; ex[2] = 32'h10000002; ex[3] = 32'h00000005;
        check_list("R4 wrap", 4);
    endtask

    // R12 ordering, R5 end time forced non-zero, R4
    task automatic t_order;
        nmk = 0;
        @(negedge clk); gate_in = 1;
        step(200); chan_in = 8'h02;
        step(1); chan_in = 8'h00;
        step(55); chan_in = 8'h40; gate_in = 0;
        step(1); chan_in = 8'h00;
        step(12);
        ex[0] = 32'h0; ex[1] = 32'h020000C8; ex[2] = 32'h000000FF;
        ex[3] = 32'h40000000; ex[4] = 32'h00000001;
        check_list("R12 R5 R4 order", 5);
        if (nmk >= 5) begin
            chk("R12 consecutive hit", mc[3] - mc[2], 1);
            chk("R12 consecutive end", mc[4] - mc[3], 1);
        end
    endtask

    // R11 event register read-clear
    task automatic t_read;
        chk("R11 last marker", evt_rdata, 32'h00000001);
        @(negedge clk); evt_rd = 1;
        @(negedge clk); evt_rd = 0;
        chk("R11 cleared", evt_rdata, 32'h0);
    endtask

    initial begin
        step(5); rst_n = 1;
        step(2);
        t_reset;
        t_basic;
        t_delay;
        t_divider;
        t_gate_time;
        t_suppress;
        t_wrap;
        t_order;
        t_read;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule